// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave serial port that gives an external master byte-wide access to a 256-address space made of clock registers and user RAM. A static mode input picks one of two wirings. The first is a four-wire SPI link with separate data-in and data-out lines, which shifts the most significant bit first. The second is a three-wire link where one shared line carries both directions, which shifts the least significant bit first. Chip enable and the serial clock are sampled by the system clock through synchronizers, and all logic runs in the system clock domain.

A transfer opens when chip enable rises. The first byte is an address whose top bit selects write (1) or read (0). Any number of data bytes follow. After each data byte the pointer advances, and it wraps inside the clock window or the RAM window, with limits that depend on the direction. On the register side the block drives a plain read/write port with a one-cycle read latency. It also drives a per-byte access strobe, so that alarm flags can clear, and a snapshot pulse at the start of every read, so that the timekeeper can freeze a user copy of the time.

The house stream style does not fit a serial slave: the master sets the pace and nothing can push back on it. For that reason every register-side pin is a plain strobe.

Top module: `serial_regport`

## Requirements
- R1: A transfer starts on a rising edge of `ce`. Any cycle with `ce` low ends the transfer, and `sdo_oe` is low from the next cycle on.
- R2: Bit 7 of the address byte selects the direction: 1 is a write and 0 is a read. Write strobes carry `reg_addr[7]`=1 and read strobes carry `reg_addr[7]`=0. The two strobes never fire in the same cycle.
- R3: SPI mode (`wire3_mode`=0) shifts bytes MSB first. The level of `sclk` at the rising edge of `ce` sets the idle polarity. Input is sampled on the trailing edge of each clock pulse (the falling edge for idle-low, the rising edge for idle-high). Output changes on the leading edge.
- R4: Three-wire mode (`wire3_mode`=1) shifts bytes LSB first. Input is sampled on rising `sclk` and output changes on falling `sclk`.
- R5: `sdo_oe` stays low during the address byte and throughout write transfers. It rises only at the first output edge of a read's data phase.
- R6: While `ce` stays high, the pointer advances by one after every data byte, in both directions.
- R7: In the clock window, a read pointer wraps from 1Fh to 00h and a write pointer wraps from 9Fh to 80h.
- R8: In the RAM window, a read pointer wraps from 7Fh to 20h and a write pointer wraps from FFh to A0h.
- R9: A data byte cut short by `ce` falling before its eighth bit produces no write.
- R10: Reads of addresses 12h to 1Fh return 00h whatever `reg_rd_data` holds.
- R11: While `wp_on` is high, writes to every address are dropped. The one exception is the control register (write address 8Fh), which is still issued but with `reg_wr_mask`=40h, so that only the protect bit (bit 6) can change. With `wp_on` low, every write has mask FFh.
- R12: `snap` pulses for one cycle when a read address byte completes. `touch` pulses once for each byte the pointer lands on: one for every completed write byte, whether protected or not, and one for every read fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| wire3_mode | input | 1 | 1 = three-wire mode with a shared line, 0 = SPI |
| ce | input | 1 | Chip enable, active high |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Serial data in (the shared line in three-wire mode) |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for `sdo` |
| reg_addr | output | 8 | Address of the current register-port access |
| reg_rd_en | output | 1 | Read strobe. Data is expected on `reg_rd_data` one cycle later |
| reg_rd_data | input | 8 | Read data from the register file |
| reg_wr_en | output | 1 | Write strobe |
| reg_wr_data | output | 8 | Write data |
| reg_wr_mask | output | 8 | Per-bit write enables |
| wp_on | input | 1 | Current state of the write-protect control bit |
| touch | output | 1 | Access strobe for each byte, qualified by `reg_addr` |
| snap | output | 1 | Read-start pulse for the time snapshot |

## Verification
Two situations are the hardest to reach from the pins. The first is the turnaround on the shared three-wire line: the slave must start driving on the falling edge that closes the address byte, only half a bit period after it latched the direction bit. The bench models the shared line as the slave's output whenever the enable is high, and the master's drive otherwise, so a late or early enable corrupts the first data bit that is read back. The second is a burst that crosses a window limit while passing through reserved addresses. A read that starts at 1Eh and runs three bytes meets two zeroed locations and then the wrap to 00h, which the register model returns as non-zero. A write byte cut to five bits confirms that a truncated byte leaves no trace in the write scoreboard.

// File: rtl/serif_pkg.sv
package serif_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W);

  // address windows, on the low seven bits of the pointer
  localparam logic [6:0] CLK_TOP  = 7'h1F;
  localparam logic [6:0] RAM_BASE = 7'h20;
  localparam logic [6:0] RAM_TOP  = 7'h7F;
  localparam logic [6:0] RSV_LO   = 7'h12;
  localparam logic [6:0] RSV_HI   = 7'h1F;
  localparam logic [6:0] CTRL_LOC = 7'h0F;
  localparam int         WP_BIT   = 6;

  typedef enum logic {PH_ADDR, PH_DATA} phase_t;

  // pointer advance with window wrap; bit 7 (direction) is preserved
  function automatic logic [BYTE_W-1:0] wrap_next(input logic [BYTE_W-1:0] a);
    if (a[6:0] == CLK_TOP)      return {a[7], 7'h00};
    else if (a[6:0] == RAM_TOP) return {a[7], RAM_BASE};
    else                        return a + 8'd1;
  endfunction

  function automatic logic in_reserved(input logic [BYTE_W-1:0] a);
    return (a[6:0] >= RSV_LO) && (a[6:0] <= RSV_HI);
  endfunction

endpackage

// File: rtl/serif_sync.sv
module serif_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[CHAIN_W-WIDTH-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/serif_edges.sv
module serif_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic wire3_mode,
  input  logic ce_s,
  input  logic sclk_s,
  output logic strobe,
  output logic shift
);
  logic sclk_q, ce_q, idle_hi;
  logic rise, fall, live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      ce_q    <= 1'b0;
      idle_hi <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      ce_q   <= ce_s;
      if (ce_s && !ce_q) idle_hi <= sclk_s;   // polarity taken as CE opens
    end
  end

  assign rise = sclk_s & ~sclk_q;
  assign fall = ~sclk_s & sclk_q;
  assign live = ce_s & ce_q;

  // three-wire: latch rising, drive falling; SPI: latch on trailing edge
  assign strobe = live & (wire3_mode ? rise : (idle_hi ? rise : fall));
  assign shift  = live & (wire3_mode ? fall : (idle_hi ? fall : rise));
endmodule

// File: rtl/serif_rx.sv
module serif_rx
  import serif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              strobe,
  input  logic              lsb_first,
  input  logic              din,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic [CNT_W-1:0]  count
);
  logic [BYTE_W-1:0] sh;

  assign byte_val  = lsb_first ? {din, sh[BYTE_W-1:1]} : {sh[BYTE_W-2:0], din};
  assign byte_done = strobe && (count == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '0;
      count <= '0;
    end else if (clear) begin
      sh    <= '0;
      count <= '0;
    end else if (strobe) begin
      sh    <= byte_val;
      count <= byte_done ? '0 : count + 1'b1;
    end
  end
endmodule

// File: rtl/serif_tx.sv
module serif_tx
  import serif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic              enable,
  input  logic              lsb_first,
  input  logic [BYTE_W-1:0] data,
  input  logic [CNT_W-1:0]  idx,
  output logic              sdo,
  output logic              oe
);
  logic [CNT_W-1:0] pos;

  assign pos = lsb_first ? idx : CNT_W'(BYTE_W-1) - idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0;
      oe  <= 1'b0;
    end else if (clear) begin
      sdo <= 1'b0;
      oe  <= 1'b0;
    end else if (shift && enable) begin
      sdo <= data[pos];
      oe  <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import serif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wire3_mode,
  input  logic              ce,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic              reg_rd_en,
  input  logic [BYTE_W-1:0] reg_rd_data,
  output logic              reg_wr_en,
  output logic [BYTE_W-1:0] reg_wr_data,
  output logic [BYTE_W-1:0] reg_wr_mask,
  input  logic              wp_on,
  output logic              touch,
  output logic              snap
);
  localparam logic [BYTE_W-1:0] FULL_MASK = '1;
  localparam logic [BYTE_W-1:0] WP_MASK   = BYTE_W'(1) << WP_BIT;

  logic [2:0] pins_s;
  logic ce_s, sclk_s, sdi_s;
  logic strobe, shift;
  logic byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [CNT_W-1:0]  bit_idx;

  phase_t            phase;
  logic              rd_dir;
  logic [BYTE_W-1:0] ptr, ptr_next;
  logic              rd_vld_q, rsv_q;
  logic [BYTE_W-1:0] rd_buf;

  serif_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ce, sclk, sdi}), .q(pins_s)
  );
  assign {ce_s, sclk_s, sdi_s} = pins_s;

  serif_edges u_edges (
    .clk(clk), .rst_n(rst_n), .wire3_mode(wire3_mode),
    .ce_s(ce_s), .sclk_s(sclk_s), .strobe(strobe), .shift(shift)
  );

  serif_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clear(!ce_s), .strobe(strobe),
    .lsb_first(wire3_mode), .din(sdi_s),
    .byte_done(byte_done), .byte_val(byte_val), .count(bit_idx)
  );

  serif_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clear(!ce_s), .shift(shift),
    .enable(phase == PH_DATA && rd_dir), .lsb_first(wire3_mode),
    .data(rd_buf), .idx(bit_idx), .sdo(sdo), .oe(sdo_oe)
  );

  assign ptr_next = wrap_next(ptr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase       <= PH_ADDR;
      rd_dir      <= 1'b0;
      ptr         <= '0;
      rd_vld_q    <= 1'b0;
      rsv_q       <= 1'b0;
      rd_buf      <= '0;
      reg_addr    <= '0;
      reg_rd_en   <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wr_data <= '0;
      reg_wr_mask <= '0;
      touch       <= 1'b0;
      snap        <= 1'b0;
    end else begin
      reg_rd_en <= 1'b0;
      reg_wr_en <= 1'b0;
      touch     <= 1'b0;
      snap      <= 1'b0;
      rd_vld_q  <= reg_rd_en;
      if (rd_vld_q) rd_buf <= rsv_q ? '0 : reg_rd_data;

      if (!ce_s) begin
        phase <= PH_ADDR;
      end else if (byte_done) begin
        if (phase == PH_ADDR) begin
          phase  <= PH_DATA;
          ptr    <= byte_val;
          rd_dir <= !byte_val[7];
          if (!byte_val[7]) begin
            reg_rd_en <= 1'b1;
            reg_addr  <= byte_val;
            rsv_q     <= in_reserved(byte_val);
            touch     <= 1'b1;
            snap      <= 1'b1;
          end
        end else if (rd_dir) begin
          ptr       <= ptr_next;
          reg_rd_en <= 1'b1;
          reg_addr  <= ptr_next;
          rsv_q     <= in_reserved(ptr_next);
          touch     <= 1'b1;
        end else begin
          ptr         <= ptr_next;
          touch       <= 1'b1;
          reg_addr    <= ptr;
          reg_wr_data <= byte_val;
          if (!wp_on) begin
            reg_wr_en   <= 1'b1;
            reg_wr_mask <= FULL_MASK;
          end else if (ptr[6:0] == CTRL_LOC) begin
            reg_wr_en   <= 1'b1;
            reg_wr_mask <= WP_MASK;
          end
        end
      end
    end
  end
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk
  import serif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ce_live,
  input logic              sdo_oe,
  input logic              rd_dir,
  input logic              reg_rd_en,
  input logic              reg_wr_en,
  input logic [BYTE_W-1:0] reg_addr,
  input logic [BYTE_W-1:0] reg_wr_mask,
  input logic              snap
);
  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_live |=> !sdo_oe);

  assert_write_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> reg_addr[7]);

  assert_read_dir_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> !reg_addr[7]);

  assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd_en && reg_wr_en));

  assert_no_drive_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> rd_dir);

  assert_protect_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_mask != 8'hFF) |->
      (reg_addr[6:0] == CTRL_LOC && reg_wr_mask == (8'h01 << WP_BIT)));

  assert_snap_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> !snap);
endmodule

bind serial_regport serial_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ce_live(ce_s), .sdo_oe(sdo_oe), .rd_dir(rd_dir),
  .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wr_mask(reg_wr_mask), .snap(snap)
);

// File: tb/serial_regport_test.sv
module serial_regport_test;
  localparam time PER  = 8ns;
  localparam time HALF = 8 * PER;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wire3 = 1'b0, ce = 1'b0, sclk = 1'b0, m_drv = 1'b0, wp = 1'b0;
  logic sdo, sdo_oe, reg_rd_en, reg_wr_en, touch, snap;
  logic [7:0] reg_addr, reg_wr_data, reg_wr_mask;
  logic [7:0] reg_rd_data = 8'h00;
  wire  sdi_w = (wire3 && sdo_oe) ? sdo : m_drv;

  int n_checks = 0, n_fail = 0, touch_cnt = 0, snap_cnt = 0;
  logic [23:0] exp_q[$];

  always #(PER/2) clk = ~clk;

  serial_regport uut (
    .clk(clk), .rst_n(rst_n), .wire3_mode(wire3), .ce(ce), .sclk(sclk), .sdi(sdi_w),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_addr(reg_addr), .reg_rd_en(reg_rd_en),
    .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_wr_mask(reg_wr_mask), .wp_on(wp), .touch(touch), .snap(snap)
  );

  // register-file model: one-cycle read latency, content = address ^ 5Ah
  always @(posedge clk) if (reg_rd_en) reg_rd_data <= reg_addr ^ 8'h5A;

  function automatic logic [7:0] nxt(input logic [7:0] a);
    if (a[6:0] == 7'h1F)      return {a[7], 7'h00};   // R7
    else if (a[6:0] == 7'h7F) return {a[7], 7'h20};   // R8
    else                      return a + 8'd1;        // R6
  endfunction

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a >= 8'h12 && a <= 8'h1F) return 8'h00;       // R10
    return a ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor for the write port
  always @(negedge clk) begin
    if (rst_n) begin
      if (touch) touch_cnt++;
      if (snap)  snap_cnt++;
      if (reg_wr_en) begin
        if (exp_q.size() == 0) check(1'b0, "R9/R11 unexpected write", {8'h0, reg_addr, reg_wr_data, reg_wr_mask}, 32'h0);
        else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check({reg_addr, reg_wr_data, reg_wr_mask} == e, "R6 write stream",
                {8'h0, reg_addr, reg_wr_data, reg_wr_mask}, {8'h0, e});
        end
      end
    end
  end

  task automatic bit_io(input logic b, input logic cpol, output logic got);
    if (!wire3) begin
      sclk = ~cpol; m_drv = b; #HALF; got = sdo; sclk = cpol; #HALF;
    end else begin
      m_drv = b; #HALF; got = sdi_w; sclk = 1'b1; #HALF; sclk = 1'b0;
    end
  endtask

  task automatic byte_io(input logic [7:0] tx, input int nbits, input logic cpol, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 0; i < nbits; i++) begin
      int idx;
      logic g;
      idx = wire3 ? i : 7 - i;
      bit_io(tx[idx], cpol, g);
      rx[idx] = g;
    end
  endtask

  task automatic open_xfer(input logic cpol);
    sclk = wire3 ? 1'b0 : cpol; m_drv = 1'b0;
    #(5*PER); ce = 1'b1; #HALF;
  endtask

  task automatic close_xfer();
    #HALF; ce = 1'b0; #(3*HALF);
    check(sdo_oe == 1'b0, "R1 release after CE low", {31'h0, sdo_oe}, 32'h0);
  endtask

  task automatic do_write(input logic [7:0] addr, input int n, input logic [7:0] d0,
                          input logic cpol, input logic prot, input string req);
    logic [7:0] a, rx;
    a = addr; wp = prot;
    for (int k = 0; k < n; k++) begin
      if (!prot) exp_q.push_back({a, d0 + 8'(k), 8'hFF});
      else if (a[6:0] == 7'h0F) exp_q.push_back({a, d0 + 8'(k), 8'h40});
      a = nxt(a);
    end
    open_xfer(cpol);
    byte_io(addr, 8, cpol, rx);
    for (int k = 0; k < n; k++) begin
      byte_io(d0 + 8'(k), 8, cpol, rx);
      check(sdo_oe == 1'b0, "R5 no drive in write", {31'h0, sdo_oe}, 32'h0);
    end
    close_xfer();
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    wp = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] addr, input int n, input logic cpol, input string req);
    logic [7:0] a, rx;
    int s0;
    a = addr; s0 = snap_cnt;
    open_xfer(cpol);
    byte_io(addr, 8, cpol, rx);
    if (!wire3) check(sdo_oe == 1'b0, "R5 quiet before data", {31'h0, sdo_oe}, 32'h0);
    for (int k = 0; k < n; k++) begin
      byte_io(8'h00, 8, cpol, rx);
      check(rx == exp_rd(a), req, rx, exp_rd(a));
      a = nxt(a);
    end
    close_xfer();
    check(snap_cnt == s0 + 1, "R12 one snap per read", snap_cnt - s0, 1);
  endtask

  initial begin
    #(150000*PER);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int t0;
    #(3*PER); rst_n = 1'b1; #(3*PER);
    @(negedge clk);
    check(!sdo_oe && !reg_wr_en && !reg_rd_en && !snap && !touch, "reset state",
          {27'h0, sdo_oe, reg_wr_en, reg_rd_en, snap, touch}, 32'h0);

    // SPI, idle-low clock: R2 R3 R6 write burst and R12 touch count
    wire3 = 1'b0;
    t0 = touch_cnt;
    do_write(8'h85, 2, 8'h3C, 1'b0, 1'b0, "R3 SPI idle-low write");
    check(touch_cnt == t0 + 2, "R12 touch per write byte", touch_cnt - t0, 2);
    // SPI, idle-high clock: R3 read burst with increment R6
    do_read(8'h03, 2, 1'b1, "R3 SPI idle-high read");
    do_read(8'h40, 3, 1'b0, "R6 SPI idle-low read burst");

    // three-wire mode: R4
    wire3 = 1'b1;
    do_write(8'hA2, 2, 8'h81, 1'b0, 1'b0, "R4 three-wire write");
    do_read(8'h21, 2, 1'b0, "R4 three-wire read");

    // window wraps: R7 R8, with reserved locations R10
    wire3 = 1'b0;
    do_read(8'h1E, 3, 1'b0, "R7 R10 clock read wrap");
    do_write(8'h9F, 2, 8'h55, 1'b1, 1'b0, "R7 clock write wrap");
    do_read(8'h7F, 2, 1'b1, "R8 RAM read wrap");
    do_write(8'hFF, 2, 8'hE0, 1'b0, 1'b0, "R8 RAM write wrap");
    wire3 = 1'b1;
    do_read(8'h11, 2, 1'b0, "R10 reserved start");

    // truncated write byte: R9
    wire3 = 1'b0;
    exp_q.push_back({8'h90, 8'h11, 8'hFF});
    open_xfer(1'b0);
    byte_io(8'h90, 8, 1'b0, rx);
    byte_io(8'h11, 8, 1'b0, rx);
    byte_io(8'h22, 5, 1'b0, rx);
    close_xfer();
    check(exp_q.size() == 0, "R9 truncated byte dropped", exp_q.size(), 0);

    // write protect: R11
    t0 = touch_cnt;
    do_write(8'h84, 1, 8'h77, 1'b0, 1'b1, "R11 protected write dropped");
    check(touch_cnt == t0 + 1, "R12 touch on blocked write", touch_cnt - t0, 1);
    do_write(8'h8F, 1, 8'hC7, 1'b1, 1'b1, "R11 control write masked");

    #(10*PER);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule